// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the access address for a four-beat burst into a synchronous memory. A new starting address is captured from the external address bus when either of two active-low address strobes is asserted. After that, an active-low advance input steps a two-bit beat counter. Only the two lowest address bits follow the burst order. The upper bits stay as they were captured.

The ordering of the two low bits is either interleaved or linear. In interleaved order the starting value is XORed with the beat index. In linear order the beat index is added to the starting value and the sum wraps within the aligned four-word block. The order select is treated as static configuration: it is captured together with the starting address and holds for that whole burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low and after its release, addr_o is 0 and beat_o is 0 until the first load.
- R2: A low strobe_ctrl_ni at a rising edge captures addr_i and clears beat_o to 0, whatever the level of ce_ni, and takes precedence over the advance input.
- R3: A low strobe_proc_ni at a rising edge while ce_ni is low captures addr_i and clears beat_o to 0.
- R4: A low strobe_proc_ni while ce_ni is high has no effect: the block behaves as if that strobe were high.
- R5: With no load, a low adv_ni at a rising edge increments beat_o by one modulo 4.
- R6: With no load and adv_ni high, addr_o and beat_o hold their values (wait state).
- R7: When mode_i was 1 at load, addr_o[1:0] equals the captured start bits XOR beat_o.
- R8: When mode_i was 0 at load, addr_o[1:0] equals the captured start bits plus beat_o, modulo 4.
- R9: addr_o bits above bit 1 equal the captured address for the whole burst, and an advance from beat 3 returns addr_o to the starting address.
- R10: mode_i is captured only at a load; changing it during a burst does not change addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_proc_ni | input | 1 | Processor-side address strobe, active low, gated by ce_ni |
| strobe_ctrl_ni | input | 1 | Controller-side address strobe, active low, ungated |
| ce_ni | input | 1 | Primary chip enable, active low |
| adv_ni | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | External starting address |
| addr_o | output | ADDR_W | Current access address |
| beat_o | output | 2 | Current beat index |

## Verification
The assertions assume that every input is stable at the rising clock edge. They also assume that mode_i is a legal 0 or 1 and is never unknown. The stimulus drives all inputs on the falling edge only. It draws them from a seeded random source, weighted so that strobes are infrequent and advances are common. This gives long bursts, wraps and wait states. The random stream also toggles mode_i in the middle of bursts, which exercises the capture rule without breaking the static-configuration assumption.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} burst_order_e;
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic strobe_proc_ni,
  input  logic strobe_ctrl_ni,
  input  logic ce_ni,
  input  logic adv_ni,
  output logic load_o,
  output logic step_o
);
  logic proc_ok;
  // processor strobe only counts while the primary enable is active
  assign proc_ok = ~strobe_proc_ni & ~ce_ni;
  assign load_o  = proc_ok | ~strobe_ctrl_ni;
  assign step_o  = ~load_o & ~adv_ni;
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
  import burst_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  step_i,
  output beat_t beat_o
);
  beat_t beat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (step_i) beat_q <= beat_q + beat_t'(1);
  end
  assign beat_o = beat_q;
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] base_o,
  output burst_order_e      order_o
);
  logic [ADDR_W-1:0] base_q;
  burst_order_e      order_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= ORD_INTERLEAVE;
    end else if (load_i) begin
      base_q  <= addr_i;
      order_q <= burst_order_e'(mode_i);
    end
  end
  assign base_o  = base_q;
  assign order_o = order_q;
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] base_i,
  input  beat_t             beat_i,
  input  burst_order_e      order_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned UPPER_W = ADDR_W - BEAT_W;
  beat_t start, low_ilv, low_lin;
  assign start   = base_i[BEAT_W-1:0];
  assign low_ilv = start ^ beat_i;
  assign low_lin = start + beat_i;  // wraps inside the aligned block
  generate
    if (UPPER_W > 0) begin : g_upper
      assign addr_o[ADDR_W-1:BEAT_W] = base_i[ADDR_W-1:BEAT_W];
    end
  endgenerate
  assign addr_o[BEAT_W-1:0] = (order_i == ORD_INTERLEAVE) ? low_ilv : low_lin;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_proc_ni,
  input  logic              strobe_ctrl_ni,
  input  logic              ce_ni,
  input  logic              adv_ni,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);
  logic              load, step;
  beat_t             beat;
  logic [ADDR_W-1:0] base;
  burst_order_e      order;

  burst_load_ctrl u_ctrl (
    .strobe_proc_ni(strobe_proc_ni), .strobe_ctrl_ni(strobe_ctrl_ni),
    .ce_ni(ce_ni), .adv_ni(adv_ni), .load_o(load), .step_o(step)
  );

  burst_beat_cnt u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step), .beat_o(beat)
  );

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .addr_i(addr_i),
    .mode_i(mode_i), .base_o(base), .order_o(order)
  );

  burst_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .base_i(base), .beat_i(beat), .order_i(order), .addr_o(addr_o)
  );

  assign beat_o = beat;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_proc_ni,
  input logic              strobe_ctrl_ni,
  input logic              ce_ni,
  input logic              adv_ni,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        beat_o
);
  logic no_load;
  assign no_load = strobe_ctrl_ni & (strobe_proc_ni | ce_ni);

  assert_ctrl_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_ctrl_ni |=> (beat_o == 2'd0) && (addr_o == $past(addr_i)));

  assert_proc_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_proc_ni && !ce_ni) |=> (beat_o == 2'd0) && (addr_o == $past(addr_i)));

  assert_proc_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_proc_ni && ce_ni && strobe_ctrl_ni && adv_ni) |=> $stable(addr_o) && $stable(beat_o));

  assert_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_load && !adv_ni) |=> beat_o == 2'($past(beat_o) + 2'd1));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_load && adv_ni) |=> $stable(addr_o) && $stable(beat_o));

  assert_upper_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_load |=> $stable(addr_o[ADDR_W-1:2]));

  assert_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_load && !adv_ni && beat_o == 2'd3) |=> beat_o == 2'd0);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_proc_ni(strobe_proc_ni),
  .strobe_ctrl_ni(strobe_ctrl_ni), .ce_ni(ce_ni), .adv_ni(adv_ni),
  .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int unsigned AW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sp_n = 1'b1, sc_n = 1'b1, ce_n = 1'b1, adv_n = 1'b1, mode = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] addr_q;
  logic [1:0]    beat_q;

  int n_run = 0, n_fail = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_mode = 1'b1;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_proc_ni(sp_n), .strobe_ctrl_ni(sc_n),
    .ce_ni(ce_n), .adv_ni(adv_n), .mode_i(mode), .addr_i(addr),
    .addr_o(addr_q), .beat_o(beat_q)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] bt, logic md);
    logic [1:0] lo;
    lo = md ? (b[1:0] ^ bt) : 2'(b[1:0] + bt);
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(string req, logic [AW+1:0] act, logic [AW+1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(string req, logic p, logic c, logic e, logic a, logic m, logic [AW-1:0] ad);
    sp_n = p; sc_n = c; ce_n = e; adv_n = a; mode = m; addr = ad;
    @(posedge clk);
    if (!c || (!p && !e)) begin
      m_base = ad; m_beat = 2'd0; m_mode = m;
    end else if (!a) m_beat = m_beat + 2'd1;
    @(negedge clk);
    chk(req, {beat_q, addr_q}, {m_beat, exp_addr(m_base, m_beat, m_mode)});
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    chk("R1 in reset", {beat_q, addr_q}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {beat_q, addr_q}, '0);
    cyc("R1 R6 idle hold", 1, 1, 1, 1, 1, 20'hABCDE);

    // interleaved from start 2: 2,3,0,1 then wrap to 2
    cyc("R2 R7 ctrl load", 1, 0, 1, 0, 1, 20'h12342);
    for (int i = 0; i < 4; i++) cyc("R5 R7 R9 interleave step", 1, 1, 1, 0, 1, '0);
    cyc("R6 wait state", 1, 1, 1, 1, 1, '0);

    // linear from start 3: 3,0,1,2 then wrap
    cyc("R3 R8 proc load", 0, 1, 0, 1, 0, 20'hFFF03);
    for (int i = 0; i < 4; i++) cyc("R5 R8 R9 linear step", 1, 1, 1, 0, 0, '0);

    // processor strobe ignored with enable high
    cyc("R4 proc ignored hold", 0, 1, 1, 1, 0, 20'h55555);
    cyc("R4 proc ignored step", 0, 1, 1, 0, 1, 20'h55555);

    // mode change mid burst
    cyc("R10 load linear", 1, 0, 0, 1, 0, 20'h00A01);
    cyc("R10 mode flips", 1, 1, 1, 0, 1, '0);
    cyc("R10 mode flips", 1, 1, 1, 0, 1, '0);

    // both strobes together
    cyc("R2 R3 both strobes", 0, 0, 0, 0, 1, 20'h7777E);

    for (int i = 0; i < 600; i++) begin
      logic p, c, e, a, m;
      p = ($urandom % 8) == 0;
      c = ($urandom % 10) == 0;
      e = $urandom % 2;
      a = ($urandom % 4) != 0;
      m = $urandom % 2;
      cyc("R2 R3 R4 R5 R6 R7 R8 R9 R10 random", ~p, ~c, e, ~a, m, AW'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule